// File: doc/BRIEF.md
# Extended interrupt vector router

The block gathers a bank of level interrupt inputs (256 by default), latches each enabled one into a sticky status bit, and steers every pending, enabled vector to one interrupt pin of one target CPU. Software sets it up through a simple word-wide write port and a combinational read port. Through these ports it reaches per-vector enable bits, per-vector status bits, per-vector 8-bit route bytes, a pin-selection word, a fixed feature word and a configuration word.

The configuration word picks, at run time, how route bytes and pin fields are decoded. In legacy form the route byte carries a node number in its upper nibble and a bitmap of cores 0 to 3 in its lower nibble. The pin field is a bitmap of pins 0 to 3. In the encoded forms, the route byte is a binary CPU index, the pin field is a binary pin index, or both. The output is a flat vector holding one group of pin lines for each CPU. Firmware retargets a vector by masking it, rewriting its route byte and unmasking it. A masked vector never reaches a pin.

Top module: `vec_router`

## Requirements
- R1: After reset, every enable, status and route bit is zero, the configuration word reads 0, and all cpu_pins are low.
- R2: The feature word at byte offset 0x304 reads bit0=1 (extension present), bit1=1 (enable option present), bit2=integer pin encoding supported and bit3=CPU encoding supported, with all other bits 0. Writes to it have no effect on what it reads.
- R3: The configuration word at 0x308 keeps bit1 (global enable), bit2 (integer pin encoding) and bit3 (CPU encoding). An encoding bit is kept only if the feature word shows it as supported. All other bits read 0.
- R4: The enable bit of vector v is bit v[4:0] of the word at byte offset 0x000 + (v>>5)*4, and that word reads back as written.
- R5: The route byte of vector v occupies bits [(v&3)*8 +: 8] of the word at 0x200 + (v & ~3), and that word reads back as written.
- R6: At each clock edge where a vector's input is high and its enable bit is set, its status bit becomes 1. The bit then stays set until a 1 is written to it in the status word at 0x100 + (v>>5)*4. If a set and a clear happen in the same cycle, the set wins. A disabled vector's status never sets.
- R7: With CPU encoding off, the target CPU is node*4 + core, where node is route[7:4] and core is the lowest set bit of route[3:0]. An all-zero core bitmap targets nothing.
- R8: With CPU encoding on, the target CPU is the binary value of the whole route byte. A target CPU of NUM_CPU or more (in either mode) delivers nothing.
- R9: The pin field of vector v is bits [4*(v>>5) +: 4] of the word at 0x300. With integer pin encoding off, the pin is the lowest set bit of the field, and a zero field targets nothing. With it on, the pin is the field's binary value.
- R10: cpu_pins[cpu*NUM_PIN + pin] is the OR over all vectors whose status and enable are both set and that target (cpu, pin). All cpu_pins are low while the global enable bit is 0.
- R11: A masked vector drives no pin, even with its status set and its route byte rewritten while masked. On unmask it drives the pin of its new route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_VEC | Level interrupt inputs, one per vector |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| wr_addr | input | 10 | Byte offset of the word written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 10 | Byte offset of the word read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cpu_pins | output | NUM_CPU*NUM_PIN | Interrupt pins, bit cpu*NUM_PIN + pin |

## Verification
The bench targets the decoding corners. These are a core bitmap with several bits set, where the wrong priority lands on a neighbouring CPU. They also include an empty bitmap or pin field, which a careless decoder turns into CPU or pin 0, and a node or CPU index just past the last CPU, which would wrap onto a low CPU. It also covers the mask, rewrite and unmask sequence, where a design that gates status instead of delivery would fire on the old route or lose the interrupt. It checks that a set and a clear in the same cycle keep the status set, since otherwise a held input would be dropped. It checks that two vectors on one pin keep it high until both are cleared.

// File: rtl/vr_pkg.sv
// Shared constants and helpers for the vector router.
// Assumes byte-addressed 32-bit words and at most 256 vectors, so that every
// offset fits in a 10-bit address.
package vr_pkg;
    localparam int unsigned ADDR_W = 10;

    localparam logic [ADDR_W-1:0] ENA_BASE  = 10'h000;
    localparam logic [ADDR_W-1:0] STS_BASE  = 10'h100;
    localparam logic [ADDR_W-1:0] RTE_BASE  = 10'h200;
    localparam logic [ADDR_W-1:0] PIN_ADDR  = 10'h300;
    localparam logic [ADDR_W-1:0] FEAT_ADDR = 10'h304;
    localparam logic [ADDR_W-1:0] CFG_ADDR  = 10'h308;

    // Decode controls held in the configuration word.
    typedef struct packed {
        logic cpu_enc;   // bit 3
        logic int_enc;   // bit 2
        logic gen;       // bit 1
    } cfg_t;

    // Lowest set bit of a 4-bit bitmap: {found, index}.
    function automatic logic [2:0] low4(input logic [3:0] b);
        if (b[0])      return 3'b100;
        else if (b[1]) return 3'b101;
        else if (b[2]) return 3'b110;
        else if (b[3]) return 3'b111;
        else           return 3'b000;
    endfunction
endpackage

// File: rtl/vr_regs.sv
// Register file of the vector router: enable words, route words, pin-map
// word, fixed feature word and configuration word, plus the read mux.
// Writes are whole 32-bit words. Writes to a status word are passed out as
// write-1-to-clear strobes. Assumes NUM_VEC is a multiple of 32.
module vr_regs
    import vr_pkg::*;
#(
    parameter int unsigned NUM_VEC     = 256,
    parameter bit          HAS_INT_ENC = 1'b1,
    parameter bit          HAS_CPU_ENC = 1'b1,
    localparam int unsigned EN_WORDS   = NUM_VEC / 32,
    localparam int unsigned RT_WORDS   = NUM_VEC / 4,
    localparam int unsigned PM_W       = EN_WORDS * 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [NUM_VEC-1:0]   status,
    output logic [31:0]          rd_data,
    output logic [NUM_VEC-1:0]   enable,
    output logic [NUM_VEC*8-1:0] route,
    output logic [PM_W-1:0]      pin_map,
    output cfg_t                 cfg,
    output logic [NUM_VEC-1:0]   sts_clr
);
    logic [31:0]     ena_q [EN_WORDS];
    logic [31:0]     rte_q [RT_WORDS];
    logic [PM_W-1:0] pin_q;
    cfg_t            cfg_q;
    logic [31:0]     feat;

    assign feat = {28'd0, HAS_CPU_ENC, HAS_INT_ENC, 1'b1, 1'b1};

    // Word writes into enable, route, pin-map and configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < EN_WORDS; w++) ena_q[w] <= '0;
            for (int w = 0; w < RT_WORDS; w++) rte_q[w] <= '0;
            pin_q <= '0;
            cfg_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < EN_WORDS; w++)
                if (wr_addr == ENA_BASE + ADDR_W'(w * 4)) ena_q[w] <= wr_data;
            for (int w = 0; w < RT_WORDS; w++)
                if (wr_addr == RTE_BASE + ADDR_W'(w * 4)) rte_q[w] <= wr_data;
            if (wr_addr == PIN_ADDR) pin_q <= wr_data[PM_W-1:0];
            if (wr_addr == CFG_ADDR) begin
                cfg_q.gen     <= wr_data[1];
                cfg_q.int_enc <= wr_data[2] & HAS_INT_ENC;
                cfg_q.cpu_enc <= wr_data[3] & HAS_CPU_ENC;
            end
        end
    end

    // Flatten storage and form the status clear strobes.
    for (genvar w = 0; w < EN_WORDS; w++) begin : g_en
        assign enable[w*32 +: 32]  = ena_q[w];
        assign sts_clr[w*32 +: 32] =
            (wr_en && wr_addr == STS_BASE + ADDR_W'(w * 4)) ? wr_data : 32'd0;
    end
    for (genvar w = 0; w < RT_WORDS; w++) begin : g_rt
        assign route[w*32 +: 32] = rte_q[w];
    end
    assign pin_map = pin_q;
    assign cfg     = cfg_q;

    // Combinational read mux over every register word.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < EN_WORDS; w++) begin
            if (rd_addr == ENA_BASE + ADDR_W'(w * 4)) rd_data = ena_q[w];
            if (rd_addr == STS_BASE + ADDR_W'(w * 4)) rd_data = status[w*32 +: 32];
        end
        for (int w = 0; w < RT_WORDS; w++)
            if (rd_addr == RTE_BASE + ADDR_W'(w * 4)) rd_data = rte_q[w];
        if (rd_addr == PIN_ADDR)  rd_data = 32'(pin_q);
        if (rd_addr == FEAT_ADDR) rd_data = feat;
        if (rd_addr == CFG_ADDR)  rd_data = {28'd0, cfg_q.cpu_enc, cfg_q.int_enc, cfg_q.gen, 1'b0};
    end
endmodule

// File: rtl/vr_status.sv
// Sticky per-vector status: sets on an enabled high input, clears on a
// write of 1. A set in the same cycle beats a clear. Assumes irq_in is
// already synchronous to clk.
module vr_status #(
    parameter int unsigned NUM_VEC = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_in,
    input  logic [NUM_VEC-1:0] enable,
    input  logic [NUM_VEC-1:0] sts_clr,
    output logic [NUM_VEC-1:0] status
);
    // Latch enabled inputs and apply write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~sts_clr) | (irq_in & enable);
    end

    // R6: a status bit only rises after its input was high while enabled.
    p_set_needs_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~$past(status) & ~$past(irq_in & enable)) == '0);

    // R6: a cleared bit with no new request is low on the next cycle.
    p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sts_clr) & ~$past(irq_in & enable) & status) == '0);
endmodule

// File: rtl/vr_target.sv
// Decodes each vector's route byte and pin field into a (cpu, pin) target
// and ORs the active vectors onto the pin lines. Legacy decode takes the
// lowest set bit of each bitmap. Targets beyond NUM_CPU or NUM_PIN are
// dropped. Assumes NUM_PIN <= 16 and NUM_CPU <= 256.
module vr_target
    import vr_pkg::*;
#(
    parameter int unsigned NUM_VEC  = 256,
    parameter int unsigned NUM_CPU  = 16,
    parameter int unsigned NUM_PIN  = 16,
    localparam int unsigned PM_W    = (NUM_VEC / 32) * 4,
    localparam int unsigned OUT_W   = NUM_CPU * NUM_PIN,
    localparam int unsigned TGT_W   = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VEC-1:0]   active,
    input  logic [NUM_VEC*8-1:0] route,
    input  logic [PM_W-1:0]      pin_map,
    input  cfg_t                 cfg,
    output logic [OUT_W-1:0]     pins
);
    // Per-vector decode followed by the OR onto the addressed pin line.
    always_comb begin
        logic [7:0] rb;
        logic [3:0] pf;
        logic [2:0] lc;
        logic [2:0] lp;
        logic       cv;
        logic       pv;
        int         cpu;
        int         pin;
        pins = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            rb = route[v*8 +: 8];
            pf = pin_map[(v/32)*4 +: 4];
            lc = low4(rb[3:0]);
            lp = low4(pf);
            if (cfg.cpu_enc) begin
                cpu = int'(rb);
                cv  = 1'b1;
            end else begin
                cpu = int'(rb[7:4]) * 4 + int'(lc[1:0]);
                cv  = lc[2];
            end
            if (cpu >= int'(NUM_CPU)) cv = 1'b0;
            if (cfg.int_enc) begin
                pin = int'(pf);
                pv  = 1'b1;
            end else begin
                pin = int'(lp[1:0]);
                pv  = lp[2];
            end
            if (pin >= int'(NUM_PIN)) pv = 1'b0;
            if (cfg.gen && active[v] && cv && pv)
                pins[TGT_W'(cpu * int'(NUM_PIN) + pin)] = 1'b1;
        end
    end

    // R10: no pin line is high while the global enable is off.
    p_pins_need_gen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|pins) |-> cfg.gen);

    // R11: a pin line is high only if some vector is both pending and unmasked.
    p_pins_need_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|pins) |-> (|active));
endmodule

// File: rtl/vec_router.sv
// Top of the extended interrupt vector router: register file, sticky
// status and target decode. Delivery is gated by enable, so masking a
// vector holds off its pin without losing its pending status.
module vec_router
    import vr_pkg::*;
#(
    parameter int unsigned NUM_VEC     = 256,
    parameter int unsigned NUM_CPU     = 16,
    parameter int unsigned NUM_PIN     = 16,
    parameter bit          HAS_INT_ENC = 1'b1,
    parameter bit          HAS_CPU_ENC = 1'b1,
    localparam int unsigned PM_W       = (NUM_VEC / 32) * 4,
    localparam int unsigned OUT_W      = NUM_CPU * NUM_PIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic [OUT_W-1:0]   cpu_pins
);
    logic [NUM_VEC-1:0]   enable;
    logic [NUM_VEC-1:0]   status;
    logic [NUM_VEC-1:0]   sts_clr;
    logic [NUM_VEC-1:0]   active;
    logic [NUM_VEC*8-1:0] route;
    logic [PM_W-1:0]      pin_map;
    cfg_t                 cfg;

    vr_regs #(
        .NUM_VEC(NUM_VEC), .HAS_INT_ENC(HAS_INT_ENC), .HAS_CPU_ENC(HAS_CPU_ENC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status(status),
        .rd_data(rd_data), .enable(enable), .route(route),
        .pin_map(pin_map), .cfg(cfg), .sts_clr(sts_clr)
    );

    vr_status #(.NUM_VEC(NUM_VEC)) u_status (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .enable(enable),
        .sts_clr(sts_clr), .status(status)
    );

    // Only pending vectors that are currently unmasked may deliver.
    assign active = status & enable;

    vr_target #(
        .NUM_VEC(NUM_VEC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN)
    ) u_target (
        .clk(clk), .rst_n(rst_n), .active(active), .route(route),
        .pin_map(pin_map), .cfg(cfg), .pins(cpu_pins)
    );
endmodule

// File: tb/tb_vec_router.sv
module tb_vec_router;
    localparam int unsigned NV = 256;
    localparam int unsigned NC = 16;
    localparam int unsigned NP = 16;
    localparam time TCLK = 20ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NV-1:0]  irq_in = '0;
    logic           wr_en = 1'b0;
    logic [9:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [9:0]     rd_addr = '0;
    logic [31:0]    rd_data;
    logic [NC*NP-1:0] cpu_pins;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    vec_router dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cpu_pins(cpu_pins)
    );

    always #(TCLK/2) clk = ~clk;

    // Table: {cfg[32:29], vec[28:21], route[20:13], pin field[12:9], hit[8], index[7:0]}
    localparam bit [32:0] TBL [12] = '{
        {4'h2, 8'd5,   8'h01, 4'b0001, 1'b1, 8'd0},
        {4'h2, 8'd37,  8'h26, 4'b1100, 1'b1, 8'd146},
        {4'h2, 8'd255, 8'h38, 4'b1000, 1'b1, 8'd243},
        {4'h2, 8'd100, 8'h41, 4'b0001, 1'b0, 8'd0},
        {4'h2, 8'd64,  8'h10, 4'b0001, 1'b0, 8'd0},
        {4'h2, 8'd2,   8'h01, 4'b0000, 1'b0, 8'd0},
        {4'hA, 8'd130, 8'h0B, 4'b0010, 1'b1, 8'd177},
        {4'hA, 8'd131, 8'h10, 4'b0001, 1'b0, 8'd0},
        {4'h6, 8'd200, 8'h05, 4'hE,    1'b1, 8'd14},
        {4'hE, 8'd77,  8'h07, 4'h0,    1'b1, 8'd112},
        {4'hE, 8'd250, 8'h0F, 4'hF,    1'b1, 8'd255},
        {4'h0, 8'd5,   8'h01, 4'b0001, 1'b0, 8'd0}
    };

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input int v);
        @(negedge clk);
        irq_in[v] = 1'b1;
        @(negedge clk);
        irq_in[v] = 1'b0;
    endtask

    function automatic logic [255:0] onehot(input int i);
        logic [255:0] r = '0;
        r[i] = 1'b1;
        return r;
    endfunction

    initial begin
        #(TCLK * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pins", 256'(cpu_pins), '0);
        rd(10'h308, d); chk("R1 config", 256'(d), '0);
        rd(10'h000, d); chk("R1 enable", 256'(d), '0);
        rd(10'h104, d); chk("R1 status", 256'(d), '0);
        rd(10'h2FC, d); chk("R1 route", 256'(d), '0);

        // R2 feature word fixed
        rd(10'h304, d); chk("R2 feature", 256'(d), 256'h0F);
        wr(10'h304, 32'h0);
        rd(10'h304, d); chk("R2 feature after write", 256'(d), 256'h0F);

        // R3 configuration bits
        wr(10'h308, 32'hFFFF_FFFF);
        rd(10'h308, d); chk("R3 config mask", 256'(d), 256'h0E);
        wr(10'h308, 32'h0);

        // R4 and R5 readback
        wr(10'h01C, 32'h8000_0001);
        rd(10'h01C, d); chk("R4 enable word", 256'(d), 256'h8000_0001);
        wr(10'h01C, 32'h0);
        wr(10'h210, 32'hA1B2_C3D4);
        rd(10'h210, d); chk("R5 route word", 256'(d), 256'hA1B2_C3D4);
        wr(10'h210, 32'h0);

        // Table walk: R7/R8/R9/R10 decode, R6 status set
        for (int e = 0; e < 12; e++) begin
            automatic logic [3:0] c  = TBL[e][32:29];
            automatic int         v  = int'(TBL[e][28:21]);
            automatic logic [7:0] rb = TBL[e][20:13];
            automatic logic [3:0] pf = TBL[e][12:9];
            automatic logic [9:0] ea = 10'h000 + 10'((v >> 5) * 4);
            automatic logic [9:0] sa = 10'h100 + 10'((v >> 5) * 4);
            automatic logic [9:0] ra = 10'h200 + 10'(v & ~3);
            wr(10'h308, {28'd0, c});
            wr(ea, 32'd1 << (v & 31));
            wr(ra, 32'(rb) << ((v & 3) * 8));
            wr(10'h300, 32'(pf) << (4 * (v >> 5)));
            pulse(v);
            rd(sa, d); chk($sformatf("R6 status entry %0d", e), 256'(d), 256'(32'd1 << (v & 31)));
            chk($sformatf("R7/R8/R9/R10 entry %0d", e), 256'(cpu_pins),
                TBL[e][8] ? onehot(int'(TBL[e][7:0])) : '0);
            wr(ea, 32'h0);
            wr(sa, 32'hFFFF_FFFF);
            wr(ra, 32'h0);
            wr(10'h300, 32'h0);
        end

        // R11 mask, rewrite route, unmask
        wr(10'h308, 32'h2);
        wr(10'h300, 32'h1);
        wr(10'h204, 32'h0000_0100);
        wr(10'h000, 32'h20);
        pulse(5);
        chk("R11 delivered before mask", 256'(cpu_pins), onehot(0));
        wr(10'h000, 32'hFFFF_FFDF);
        chk("R11 masked", 256'(cpu_pins), '0);
        wr(10'h204, 32'h0000_0200);
        chk("R11 masked after rewrite", 256'(cpu_pins), '0);
        rd(10'h100, d); chk("R11 status kept while masked", 256'(d), 256'h20);
        wr(10'h000, 32'hFFFF_FFFF);
        chk("R11 unmask new route", 256'(cpu_pins), onehot(16));
        wr(10'h000, 32'h0);
        wr(10'h100, 32'hFFFF_FFFF);
        wr(10'h204, 32'h0);

        // R10 OR of two vectors and global enable gate
        wr(10'h308, 32'hE);
        wr(10'h300, 32'h50);
        wr(10'h228, 32'h0000_0303);
        wr(10'h004, 32'h300);
        pulse(40);
        pulse(41);
        chk("R10 shared pin", 256'(cpu_pins), onehot(53));
        wr(10'h308, 32'hC);
        chk("R10 global enable off", 256'(cpu_pins), '0);
        wr(10'h308, 32'hE);
        wr(10'h104, 32'h100);
        chk("R10 one of two cleared", 256'(cpu_pins), onehot(53));
        wr(10'h104, 32'h200);
        chk("R10 both cleared", 256'(cpu_pins), '0);

        // R6 set beats clear, disabled vector ignored
        @(negedge clk);
        irq_in[40] = 1'b1;
        irq_in[42] = 1'b1;
        wr(10'h104, 32'h100);
        rd(10'h104, d); chk("R6 set wins over clear", 256'(d), 256'h100);
        @(negedge clk);
        irq_in[40] = 1'b0;
        irq_in[42] = 1'b0;
        wr(10'h104, 32'h100);
        rd(10'h104, d); chk("R6 cleared and disabled stays low", 256'(d), '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule